// File: doc/BRIEF.md
# Programmable-Polynomial CRC-32 Checker

This block computes a 32-bit cyclic redundancy check over a stream of 32-bit words. The generator polynomial and the expected final residue sit in one 64-bit configuration register that software can rewrite. A message is marked by a start flag on its first word and an end flag on its last word. When the last word is taken in, the block compares the remainder with the programmed residue and records the result. A message that carries its own complemented check value therefore reads back as a match when it arrived intact.

Software reaches the block through a four-entry register port. The entries are configuration, status, interrupt mask and reset control. Configuration writes are checked: a write while a message is open, or one that would clear the constant term of the polynomial, is refused and flagged. There are two reset levels. A light re-initialisation clears the message state and the flags but keeps the configuration and the mask. A full software reset behaves like the hardware reset. Both levels run a fixed 8-cycle initialisation, and a flag is raised when it ends. An interrupt line combines the masked flags.

Register addresses: 0 configuration, 1 status, 2 mask, 3 reset control. Status bits: 0 reset-done, 1 done, 2 error (context or polynomial), 3 match, 4 context error, 5 polynomial error, 6 message open, 7 initialising.

Top module: `crcp_engine`

## Requirements
- R1: After hardware reset, address 0 reads the polynomial 0x04C11DB7 in bits 31:0 and the residue 0xC704DD7B in bits 63:32, and address 2 reads 0.
- R2: After any reset or re-initialisation, status bit 7 is 1 for 8 cycles. Input words are not taken in during that time. At the end, bit 7 drops and reset-done (bit 0) is set.
- R3: The remainder is preset to all ones on a start word and advances by one 32-bit word per clock, most significant bit first. Polynomial bit i is the coefficient of x^i, and the x^32 term is implied.
- R4: When an end word is taken in, match (bit 3) records whether the new remainder equals the residue, and done (bit 1) is set one cycle later. A word with both start and end flags is a one-word message. Bit 6 is 1 while a message is open.
- R5: A write to address 0 while a message is open leaves the configuration unchanged and sets bits 4 and 2.
- R6: A write to address 0 whose bit 0 is 0 leaves the configuration unchanged and sets bits 5 and 2.
- R7: An accepted configuration write persists across messages. Re-initialisation (address 3, bit 0) keeps the configuration and the mask but clears the flags.
- R8: Full software reset (address 3, bit 1) restores the R1 defaults and clears the mask.
- R9: Writes to address 1 have no effect on the status.
- R10: irq is 1 exactly when a status flag is set and its mask bit is set. Mask bit 0 covers reset-done, bit 1 covers done, and bit 2 covers error.
- R11: Taking in a start word clears reset-done, done, error, match, context error and polynomial error.
- R12: Valid words with no start flag while no message is open are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| din_valid | input | 1 | Input word valid |
| din_sof | input | 1 | First word of a message |
| din_eof | input | 1 | Last word of a message |
| din | input | 32 | Input data word |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest situation to reach is a configuration write that lands while a message is open. It only happens after a start word has been taken in and before its end word arrives. The stimulus opens a message, issues the write in the very next cycle, and only then closes the message. A second hard case is a start word driven during the 8-cycle initialisation window. The bench applies it in the cycle right after reset is released, so the refusal is tied to the countdown rather than to reset itself.

// File: rtl/crcp_pkg.sv
package crcp_pkg;

    localparam int          CRC_W        = 32;
    localparam logic [31:0] POLY_DEF     = 32'h04C1_1DB7;
    localparam logic [31:0] RES_DEF      = 32'hC704_DD7B;
    localparam int          INIT_CYC_DEF = 8;
    localparam int          MSK_W        = 3;

    typedef enum logic [1:0] {
        RA_CFG  = 2'd0,
        RA_STAT = 2'd1,
        RA_MASK = 2'd2,
        RA_RCTL = 2'd3
    } reg_addr_e;

    localparam int RCTL_MINIT = 0;
    localparam int RCTL_SWRST = 1;

    // first member is the most significant bit
    typedef struct packed {
        logic initing;   // 7
        logic active;    // 6
        logic poly_err;  // 5
        logic ctx_err;   // 4
        logic match;     // 3
        logic ei;        // 2
        logic di;        // 1
        logic rd;        // 0
    } status_t;

    localparam int STAT_W = $bits(status_t);

    function automatic logic [MSK_W-1:0] irq_sources(status_t s);
        return {s.ei, s.di, s.rd};
    endfunction

endpackage

// File: rtl/crcp_cfg.sv
module crcp_cfg #(
    parameter int             W        = crcp_pkg::CRC_W,
    parameter logic [W-1:0]   POLY_RST = crcp_pkg::POLY_DEF,
    parameter logic [W-1:0]   RES_RST  = crcp_pkg::RES_DEF
) (
    input  logic           clk,
    input  logic           hard_clr,
    input  logic           wr_en,
    input  logic [2*W-1:0] wdata,
    input  logic           msg_active,
    output logic [W-1:0]   poly,
    output logic [W-1:0]   residue,
    output logic           ctx_evt,
    output logic           poly_evt
);

    logic take;

    // R5: writes are refused while a message is open
    assign ctx_evt  = wr_en & msg_active;
    // R6: the constant term must stay present
    assign poly_evt = wr_en & ~msg_active & ~wdata[0];
    assign take     = wr_en & ~msg_active & wdata[0];

    always_ff @(posedge clk) begin
        if (hard_clr) begin
            poly    <= POLY_RST;
            residue <= RES_RST;
        end else if (take) begin
            poly    <= wdata[W-1:0];
            residue <= wdata[2*W-1:W];
        end
    end

endmodule

// File: rtl/crcp_datapath.sv
module crcp_datapath #(
    parameter int W = crcp_pkg::CRC_W
) (
    input  logic         clk,
    input  logic         soft_clr,
    input  logic         accept_ok,
    input  logic         din_valid,
    input  logic         din_sof,
    input  logic         din_eof,
    input  logic [W-1:0] din,
    input  logic [W-1:0] poly,
    input  logic [W-1:0] residue,
    output logic [W-1:0] crc_q,
    output logic         active,
    output logic         sof_acc,
    output logic         eof_acc,
    output logic         match_now,
    output logic         fin_q
);

    logic [W-1:0] stage [0:W];
    logic         word_acc;
    logic         upd;

    // R3: preset on the start word, else carry the running remainder
    assign stage[0] = din_sof ? {W{1'b1}} : crc_q;

    // R3: one unrolled division stage per input bit, MSB first
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic fb;
        assign fb          = stage[gi][W-1] ^ din[W-1-gi];
        assign stage[gi+1] = {stage[gi][W-2:0], 1'b0} ^ (poly & {W{fb}});
    end

    assign word_acc  = din_valid & accept_ok;
    assign sof_acc   = word_acc & din_sof;
    // R12: no start flag and no open message -> dropped
    assign upd       = sof_acc | (word_acc & ~din_sof & active);
    assign eof_acc   = upd & din_eof;
    assign match_now = (stage[W] == residue);

    always_ff @(posedge clk) begin
        if (soft_clr) begin
            crc_q  <= {W{1'b1}};
            active <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= eof_acc;
            if (upd) crc_q <= stage[W];
            if (sof_acc)      active <= ~din_eof;
            else if (eof_acc) active <= 1'b0;
        end
    end

endmodule

// File: rtl/crcp_ctrl.sv
module crcp_ctrl
    import crcp_pkg::*;
#(
    parameter int INIT_CYC = crcp_pkg::INIT_CYC_DEF,
    parameter int MW       = crcp_pkg::MSK_W
) (
    input  logic          clk,
    input  logic          hard_clr,
    input  logic          soft_clr,
    input  logic          mask_wr,
    input  logic [MW-1:0] mask_wdata,
    input  logic          sof_acc,
    input  logic          eof_acc,
    input  logic          match_now,
    input  logic          fin,
    input  logic          ctx_evt,
    input  logic          poly_evt,
    input  logic          active,
    output status_t       st,
    output logic [MW-1:0] mask,
    output logic          irq
);

    localparam int CNT_W = $clog2(INIT_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic rd_q, di_q, match_q, ctx_q, pe_q;

    // R7/R8: mask survives re-initialisation, cleared by full reset
    always_ff @(posedge clk) begin
        if (hard_clr)     mask <= '0;
        else if (mask_wr) mask <= mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (soft_clr) begin
            cnt     <= CNT_W'(INIT_CYC);
            rd_q    <= 1'b0;
            di_q    <= 1'b0;
            match_q <= 1'b0;
            ctx_q   <= 1'b0;
            pe_q    <= 1'b0;
        end else begin
            if (cnt != '0) cnt <= cnt - CNT_W'(1);
            if (sof_acc) begin            // R11
                rd_q    <= 1'b0;
                di_q    <= 1'b0;
                match_q <= 1'b0;
                ctx_q   <= 1'b0;
                pe_q    <= 1'b0;
            end
            if (cnt == CNT_W'(1)) rd_q <= 1'b1;   // R2
            if (eof_acc) match_q <= match_now;    // R4
            if (fin)     di_q    <= 1'b1;         // R4
            if (ctx_evt) ctx_q   <= 1'b1;         // R5
            if (poly_evt) pe_q   <= 1'b1;         // R6
        end
    end

    always_comb begin
        st.initing  = (cnt != '0);
        st.active   = active;
        st.poly_err = pe_q;
        st.ctx_err  = ctx_q;
        st.match    = match_q;
        st.ei       = ctx_q | pe_q;
        st.di       = di_q;
        st.rd       = rd_q;
    end

    assign irq = |(irq_sources(st) & mask);   // R10

endmodule

// File: rtl/crcp_engine.sv
module crcp_engine
    import crcp_pkg::*;
#(
    parameter int           W        = crcp_pkg::CRC_W,
    parameter int           INIT_CYC = crcp_pkg::INIT_CYC_DEF,
    parameter logic [W-1:0] POLY_RST = crcp_pkg::POLY_DEF,
    parameter logic [W-1:0] RES_RST  = crcp_pkg::RES_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [1:0]     reg_addr,
    input  logic [2*W-1:0] reg_wdata,
    output logic [2*W-1:0] reg_rdata,
    input  logic           din_valid,
    input  logic           din_sof,
    input  logic           din_eof,
    input  logic [W-1:0]   din,
    output logic           irq
);

    localparam int MW = crcp_pkg::MSK_W;

    logic          rctl_wr, sw_rst, minit, hard_clr, soft_clr;
    logic          cfg_wr, mask_wr;
    logic [W-1:0]  poly_q, res_q, crc_q;
    logic          ctx_evt, poly_evt;
    logic          active, sof_acc, eof_acc, match_now, fin_q;
    status_t       st;
    logic [MW-1:0] mask_q;

    assign rctl_wr  = reg_wr && (reg_addr == RA_RCTL);
    assign sw_rst   = rctl_wr && reg_wdata[RCTL_SWRST];
    assign minit    = rctl_wr && reg_wdata[RCTL_MINIT];
    assign hard_clr = rst | sw_rst;
    assign soft_clr = hard_clr | minit;
    assign cfg_wr   = reg_wr && (reg_addr == RA_CFG);
    assign mask_wr  = reg_wr && (reg_addr == RA_MASK);
    // R9: address 1 has no write decode

    crcp_cfg #(.W(W), .POLY_RST(POLY_RST), .RES_RST(RES_RST)) u_cfg (
        .clk        (clk),
        .hard_clr   (hard_clr),
        .wr_en      (cfg_wr),
        .wdata      (reg_wdata),
        .msg_active (active),
        .poly       (poly_q),
        .residue    (res_q),
        .ctx_evt    (ctx_evt),
        .poly_evt   (poly_evt)
    );

    crcp_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .soft_clr  (soft_clr),
        .accept_ok (~st.initing),
        .din_valid (din_valid),
        .din_sof   (din_sof),
        .din_eof   (din_eof),
        .din       (din),
        .poly      (poly_q),
        .residue   (res_q),
        .crc_q     (crc_q),
        .active    (active),
        .sof_acc   (sof_acc),
        .eof_acc   (eof_acc),
        .match_now (match_now),
        .fin_q     (fin_q)
    );

    crcp_ctrl #(.INIT_CYC(INIT_CYC), .MW(MW)) u_ctrl (
        .clk        (clk),
        .hard_clr   (hard_clr),
        .soft_clr   (soft_clr),
        .mask_wr    (mask_wr),
        .mask_wdata (reg_wdata[MW-1:0]),
        .sof_acc    (sof_acc),
        .eof_acc    (eof_acc),
        .match_now  (match_now),
        .fin        (fin_q),
        .ctx_evt    (ctx_evt),
        .poly_evt   (poly_evt),
        .active     (active),
        .st         (st),
        .mask       (mask_q),
        .irq        (irq)
    );

    always_comb begin
        unique case (reg_addr)
            RA_CFG:  reg_rdata = {res_q, poly_q};
            RA_STAT: reg_rdata = {{(2*W-STAT_W){1'b0}}, st};
            RA_MASK: reg_rdata = {{(2*W-MW){1'b0}}, mask_q};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crcp_engine_chk.sv
module crcp_engine_chk #(
    parameter int           W        = crcp_pkg::CRC_W,
    parameter int           MW       = crcp_pkg::MSK_W,
    parameter logic [W-1:0] POLY_RST = crcp_pkg::POLY_DEF,
    parameter logic [W-1:0] RES_RST  = crcp_pkg::RES_DEF
) (
    input logic          clk,
    input logic          rst,
    input logic          hard_clr,
    input logic          soft_clr,
    input logic          sw_rst,
    input logic          minit,
    input logic          cfg_wr,
    input logic          active,
    input logic [W-1:0]  poly,
    input logic [W-1:0]  residue,
    input logic [W-1:0]  crc_q,
    input logic [MW-1:0] mask,
    input logic          eof_acc,
    input logic          fin,
    input logic          st_di,
    input logic          st_rd,
    input logic          st_ctx,
    input logic          st_initing,
    input logic          irq
);

    AST_POLY_LSB_SET: assert property (@(posedge clk) disable iff (rst)
        poly[0]);  // R6

    AST_CFG_LOCKED_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && active && !soft_clr) |=> ($stable(poly) && $stable(residue) && st_ctx));  // R5

    AST_FIN_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
        (eof_acc && !soft_clr) |=> fin);  // R4

    AST_DONE_AFTER_FIN: assert property (@(posedge clk) disable iff (rst)
        (fin && !soft_clr) |=> st_di);  // R4

    AST_HOLD_IN_INIT: assert property (@(posedge clk) disable iff (rst)
        (st_initing && !soft_clr) |=> $stable(crc_q));  // R2

    AST_RD_ON_INIT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(st_initing) |-> st_rd);  // R2

    AST_SWRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (poly == POLY_RST && residue == RES_RST && mask == '0));  // R8

    AST_MINIT_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        (minit && !hard_clr) |=> ($stable(poly) && $stable(residue) && $stable(mask)));  // R7

    AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);  // R10

endmodule

bind crcp_engine crcp_engine_chk #(
    .W(W), .MW(MW), .POLY_RST(POLY_RST), .RES_RST(RES_RST)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hard_clr   (hard_clr),
    .soft_clr   (soft_clr),
    .sw_rst     (sw_rst),
    .minit      (minit),
    .cfg_wr     (cfg_wr),
    .active     (active),
    .poly       (poly_q),
    .residue    (res_q),
    .crc_q      (crc_q),
    .mask       (mask_q),
    .eof_acc    (eof_acc),
    .fin        (fin_q),
    .st_di      (st.di),
    .st_rd      (st.rd),
    .st_ctx     (st.ctx_err),
    .st_initing (st.initing),
    .irq        (irq)
);

// File: tb/sim_crcp_engine.sv
module sim_crcp_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        din_valid = 1'b0, din_sof = 1'b0, din_eof = 1'b0;
    logic [31:0] din = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;  // 50 MHz

    crcp_engine u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .din_valid(din_valid),
        .din_sof(din_sof), .din_eof(din_eof), .din(din), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [31:0] bcrc(logic [31:0] seed, logic [31:0] d, logic [31:0] g);
        logic [31:0] r = seed;
        for (int i = 31; i >= 0; i--) begin
            logic top = r[31] ^ d[i];
            r = r << 1;
            if (top) r = r ^ g;
        end
        return r;
    endfunction

    logic [31:0] m_poly, m_res, m_crc;
    logic [2:0]  m_mask;
    int          m_cnt;
    logic        m_act, m_fin, m_rd, m_di, m_match, m_ctx, m_pe;

    task automatic m_soft();
        m_crc = '1; m_act = 0; m_fin = 0; m_rd = 0; m_di = 0;
        m_match = 0; m_ctx = 0; m_pe = 0; m_cnt = 8;
    endtask

    function automatic logic [7:0] m_status();
        return {m_cnt != 0, m_act, m_pe, m_ctx, m_match, m_ctx | m_pe, m_di, m_rd};
    endfunction

    function automatic logic [63:0] m_read(logic [1:0] a);
        case (a)
            2'd0: return {m_res, m_poly};
            2'd1: return {56'b0, m_status()};
            2'd2: return {61'b0, m_mask};
            default: return 64'b0;
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        logic rctl, acc, sof_a, upd, eof_a;
        logic [31:0] nc;
        rctl = reg_wr && reg_addr == 2'd3;
        if (rst || (rctl && reg_wdata[1])) begin
            m_poly = 32'h04C11DB7; m_res = 32'hC704DD7B; m_mask = '0;
            m_soft();
        end else if (rctl && reg_wdata[0]) begin
            m_soft();
        end else begin
            acc   = din_valid && (m_cnt == 0);
            sof_a = acc && din_sof;
            upd   = sof_a || (acc && m_act);
            nc    = bcrc(sof_a ? 32'hFFFF_FFFF : m_crc, din, m_poly);
            eof_a = upd && din_eof;
            if (sof_a) begin
                m_rd = 0; m_di = 0; m_match = 0; m_ctx = 0; m_pe = 0;
            end
            if (m_cnt == 1) m_rd = 1;
            if (eof_a) m_match = (nc == m_res);
            if (m_fin) m_di = 1;
            if (reg_wr && reg_addr == 2'd0) begin
                if (m_act) m_ctx = 1;
                else if (!reg_wdata[0]) m_pe = 1;
                else begin m_poly = reg_wdata[31:0]; m_res = reg_wdata[63:32]; end
            end
            if (reg_wr && reg_addr == 2'd2) m_mask = reg_wdata[2:0];
            m_fin = eof_a;
            if (upd) m_crc = nc;
            if (sof_a) m_act = !din_eof; else if (eof_a) m_act = 0;
            if (m_cnt > 0) m_cnt--;
        end
        started = 1;
        #5;
        if (started && !done_flag) begin
            chk("R3 per-cycle register read vs model", reg_rdata, m_read(reg_addr));
            chk("R10 per-cycle irq vs model", {63'b0, irq},
                {63'b0, |({m_ctx | m_pe, m_di, m_rd} & m_mask)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(logic w, logic [1:0] a, logic [63:0] wd,
                         logic v, logic s, logic e, logic [31:0] d);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = wd;
        din_valid = v; din_sof = s; din_eof = e; din = d;
    endtask

    task automatic wr(logic [1:0] a, logic [63:0] wd);
        drive(1, a, wd, 0, 0, 0, 0);
    endtask

    task automatic rd(logic [1:0] a, output logic [63:0] v);
        drive(0, a, 0, 0, 0, 0, 0);
        #1 v = reg_rdata;
    endtask

    task automatic send(logic s, logic e, logic [31:0] d);
        drive(0, 2'd1, 0, 1, s, e, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 2'd1, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [63:0] v;
        logic [31:0] c, r;
        repeat (3) @(negedge clk);
        rst = 0;

        // R2: start word during initialisation is refused
        send(1, 0, 32'h1234_5678);
        rd(2'd1, v);
        chk("R2 initialising, word refused", {56'b0, v[7:6]}, 64'h2);
        rd(2'd0, v);
        chk("R1 default polynomial and residue", v, 64'hC704DD7B_04C11DB7);
        rd(2'd2, v);
        chk("R1 mask cleared", v, 64'h0);
        idle(8);
        rd(2'd1, v);
        chk("R2 reset-done after init", v, 64'h01);

        // R3/R4: intact message with appended complemented check value
        c = bcrc(32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h04C11DB7);
        c = bcrc(c, 32'h0102_0304, 32'h04C11DB7);
        c = bcrc(c, 32'hA5A5_5A5A, 32'h04C11DB7);
        send(1, 0, 32'hDEAD_BEEF);
        send(0, 0, 32'h0102_0304);
        send(0, 0, 32'hA5A5_5A5A);
        send(0, 1, ~c);
        rd(2'd1, v);
        chk("R4 match recorded, done not yet", {56'b0, v[7:0]}, 64'h08);
        rd(2'd1, v);
        chk("R4 done one cycle later (R11 rd cleared)", v, 64'h0A);

        // R4: corrupted message
        send(1, 0, 32'hDEAD_BEEF);
        send(0, 1, 32'h0000_0001);
        idle(2);
        rd(2'd1, v);
        chk("R4 mismatch", v, 64'h02);

        // R4: one-word message
        send(1, 1, 32'hCAFE_F00D);
        idle(1);
        rd(2'd1, v);
        chk("R4 single word", v, {56'b0, 4'b0, (bcrc(32'hFFFF_FFFF, 32'hCAFE_F00D, 32'h04C11DB7) == 32'hC704DD7B), 3'b010});

        // R5: write while open
        send(1, 0, 32'h5555_AAAA);
        wr(2'd0, 64'h1111_2222_3333_4445);
        rd(2'd0, v);
        chk("R5 cfg unchanged", v, 64'hC704DD7B_04C11DB7);
        rd(2'd1, v);
        chk("R5 context error flagged", {56'b0, v[6], v[4], v[2]}, 64'h7);
        send(0, 1, 32'h0);
        idle(2);

        // R6: polynomial without constant term
        wr(2'd0, 64'h1111_2222_3333_4444);
        rd(2'd0, v);
        chk("R6 cfg unchanged", v, 64'hC704DD7B_04C11DB7);
        rd(2'd1, v);
        chk("R6 polynomial error flagged", {56'b0, v[5], v[2]}, 64'h3);

        // R7/R3: custom polynomial with computed residue
        r = bcrc(32'hFFFF_FFFF, 32'h0BAD_F00D, 32'h1EDC6F41);
        r = bcrc(r, 32'h7777_1234, 32'h1EDC6F41);
        wr(2'd0, {r, 32'h1EDC6F41});
        rd(2'd0, v);
        chk("R7 custom cfg accepted", v, {r, 32'h1EDC6F41});
        for (int k = 0; k < 2; k++) begin
            send(1, 0, 32'h0BAD_F00D);
            send(0, 1, 32'h7777_1234);
            idle(2);
            rd(2'd1, v);
            chk("R7 custom polynomial persists (R11 flags cleared)", v, 64'h0A);
        end

        // R10: mask behaviour, done is set
        wr(2'd2, 64'h0);
        rd(2'd1, v);
        chk("R10 masked off", {63'b0, irq}, 64'h0);
        wr(2'd2, 64'h2);
        rd(2'd1, v);
        chk("R10 done enabled", {63'b0, irq}, 64'h1);
        wr(2'd2, 64'h1);
        rd(2'd1, v);
        chk("R10 rd only, rd clear", {63'b0, irq}, 64'h0);

        // R9: status write ignored
        wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd1, v);
        chk("R9 status unchanged", v, 64'h0A);

        // R7: re-initialisation keeps cfg and mask
        wr(2'd2, 64'h3);
        wr(2'd3, 64'h1);
        rd(2'd1, v);
        chk("R7 flags cleared, initialising", v, 64'h80);
        rd(2'd0, v);
        chk("R7 cfg kept", v, {r, 32'h1EDC6F41});
        rd(2'd2, v);
        chk("R7 mask kept", v, 64'h3);
        idle(8);
        rd(2'd1, v);
        chk("R10 irq from reset-done", {56'b0, v[7:0]} | {63'b0, irq} << 8, 64'h101);

        // R12: stray word ignored
        send(0, 0, 32'h9999_9999);
        rd(2'd1, v);
        chk("R12 stray word dropped", {63'b0, v[6]}, 64'h0);

        // R8: full software reset
        wr(2'd3, 64'h2);
        rd(2'd0, v);
        chk("R8 cfg defaults", v, 64'hC704DD7B_04C11DB7);
        rd(2'd2, v);
        chk("R8 mask cleared", v, 64'h0);
        idle(10);
        rd(2'd1, v);
        chk("R8 reset-done after software reset", v, 64'h01);

        idle(2);
        finish_run();
    end

endmodule